// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Two-Level Operation Decode

This block is the execute-stage arithmetic unit of a simple processor datapath, delivered together with the small decoder that chooses its operation. The main control logic supplies a 2-bit operation class, and the instruction supplies a 6-bit function field. The decoder turns these two values into a 4-bit operation code. The datapath then applies that code to two 32-bit operands. It returns the result, a flag that is set when the result is zero, and a signed-overflow flag.

The operation code has a fixed structure. Bit 3 inverts operand B and forces a carry-in of one, so that a single adder performs both addition and subtraction. Bit 2 chooses between the adder path and the bitwise path. Bits 1:0 choose one function within the selected path. The whole block is combinational, so its outputs follow its inputs within the same cycle. The operation code is also brought out as a port, which lets the surrounding datapath and the bench observe the decode directly.

Top module: `opsel_alu`

## Requirements
- R1: When op_class is 2'b00, alu_ctl is 4'b0110 (add) for every fn_code.
- R2: When op_class is 2'b01, alu_ctl is 4'b1110 (subtract) for every fn_code.
- R3: When op_class[1] is 1, only fn_code[3:0] is decoded and fn_code[5:4] has no effect. The decode is: 0000 gives 0110 (add), 0010 gives 1110 (subtract), 0100 gives 0000 (and), 0101 gives 0001 (or), 0110 gives 0010 (xor), 0111 gives 0011 (nor), 1010 gives 1111 (set-less-than). Every other low nibble gives 0110 (add).
- R4: Codes 0000, 0001, 0010 and 0011 produce the bitwise AND, OR, XOR and NOR of opnd_a and opnd_b.
- R5: Code 0110 produces opnd_a + opnd_b modulo 2^32, and code 1110 produces opnd_a - opnd_b modulo 2^32.
- R6: Code 1111 produces 1 in bit 0 when opnd_a < opnd_b as two's-complement numbers, and 0 otherwise. All other result bits are 0. The comparison is correct even when opnd_a - opnd_b overflows.
- R7: ovf is 1 only under codes 0110 and 1110, and only when the true signed sum or difference does not fit in 32 bits. Under every other code, ovf is 0.
- R8: is_zero is 1 exactly when all 32 bits of result are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the main control: 00 add, 01 subtract, 1x use the function field |
| fn_code | input | 6 | Function field of the instruction; only bits 3:0 are decoded |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| alu_ctl | output | 4 | Decoded 4-bit operation code |
| result | output | 32 | Operation result |
| is_zero | output | 1 | High when result is all zeros |
| ovf | output | 1 | Signed overflow of an add or a subtract |

## Verification
The hardest case to reach is a set-less-than whose internal subtraction overflows. In that case the raw sign of the difference gives the wrong answer, and only the overflow correction produces the right one. To reach it reliably, the bench uses a fixed set of operand values that includes the most positive and most negative numbers and their near neighbours, and it crosses every value in the set with every other. It applies these pairs under every combination of operation class and function code, including unlisted codes and codes with the ignored upper function bits set. This also covers the overflow boundaries of add and subtract, and zero results that arise from subtraction and from the bitwise operations.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;

    // 4-bit operation code: bit 3 = invert B and carry in, bit 2 = adder path,
    // bits 1:0 = function within the selected path
    typedef enum logic [3:0] {
        OPC_AND = 4'b0000,
        OPC_OR  = 4'b0001,
        OPC_XOR = 4'b0010,
        OPC_NOR = 4'b0011,
        OPC_ADD = 4'b0110,
        OPC_SUB = 4'b1110,
        OPC_SLT = 4'b1111
    } alu_opc_e;

    typedef enum logic [1:0] {
        CLS_ADD  = 2'b00,
        CLS_SUB  = 2'b01,
        CLS_FUNC = 2'b10
    } op_class_e;

    localparam int unsigned OPC_W = 4;
    localparam int unsigned FN_W  = 6;
    localparam int unsigned FN_DEC_W = 4;

    // Adder path selector values in bits 1:0 when bit 2 is set
    localparam logic [1:0] ARITH_SUM = 2'b10;
    localparam logic [1:0] ARITH_LT  = 2'b11;

    function automatic alu_opc_e fn_nibble_to_opc(input logic [FN_DEC_W-1:0] nib);
        alu_opc_e opc;
        case (nib)
            4'b0000: opc = OPC_ADD;
            4'b0010: opc = OPC_SUB;
            4'b0100: opc = OPC_AND;
            4'b0101: opc = OPC_OR;
            4'b0110: opc = OPC_XOR;
            4'b0111: opc = OPC_NOR;
            4'b1010: opc = OPC_SLT;
            default: opc = OPC_ADD;
        endcase
        return opc;
    endfunction

endpackage

// File: rtl/opsel_alu_decode.sv
module opsel_alu_decode
    import opsel_alu_pkg::*;
(
    input  logic [1:0]      op_class,
    input  logic [FN_W-1:0] fn_code,
    output alu_opc_e        opc
);
    logic unused_fn_hi;
    assign unused_fn_hi = ^fn_code[FN_W-1:FN_DEC_W];

    always_comb begin
        if (op_class[1]) begin
            opc = fn_nibble_to_opc(fn_code[FN_DEC_W-1:0]);
        end else if (op_class[0]) begin
            opc = OPC_SUB;
        end else begin
            opc = OPC_ADD;
        end
    end
endmodule

// File: rtl/opsel_alu_addsub.sv
module opsel_alu_addsub #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             negate_b,
    output logic [WIDTH-1:0] sum,
    output logic             sgn_ovf
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] cin_vec;

    assign b_eff   = negate_b ? ~b : b;
    assign cin_vec = {{(WIDTH-1){1'b0}}, negate_b};
    assign sum     = a + b_eff + cin_vec;
    assign sgn_ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
endmodule

// File: rtl/opsel_alu_bitwise.sv
module opsel_alu_bitwise #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] y
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            case (sel)
                2'b00:   y[i] = a[i] & b[i];
                2'b01:   y[i] = a[i] | b[i];
                2'b10:   y[i] = a[i] ^ b[i];
                default: y[i] = ~(a[i] | b[i]);
            endcase
        end
    end
endmodule

// File: rtl/opsel_alu.sv
module opsel_alu
    import opsel_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [1:0]       op_class,
    input  logic [5:0]       fn_code,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [3:0]       alu_ctl,
    output logic [WIDTH-1:0] result,
    output logic             is_zero,
    output logic             ovf
);
    localparam int unsigned MSB = WIDTH - 1;

    alu_opc_e         opc;
    logic [WIDTH-1:0] sum;
    logic             sum_ovf;
    logic [WIDTH-1:0] bit_y;
    logic             a_less;
    logic             arith_sum_sel;

    opsel_alu_decode u_decode (
        .op_class (op_class),
        .fn_code  (fn_code),
        .opc      (opc)
    );

    opsel_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a        (opnd_a),
        .b        (opnd_b),
        .negate_b (opc[3]),
        .sum      (sum),
        .sgn_ovf  (sum_ovf)
    );

    opsel_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a   (opnd_a),
        .b   (opnd_b),
        .sel (opc[1:0]),
        .y   (bit_y)
    );

    // Signed less-than: difference sign corrected by overflow
    assign a_less        = sum[MSB] ^ sum_ovf;
    assign arith_sum_sel = opc[2] && (opc[1:0] == ARITH_SUM);

    always_comb begin
        if (!opc[2]) begin
            result = bit_y;
        end else if (opc[1:0] == ARITH_LT) begin
            result = {{(WIDTH-1){1'b0}}, a_less};
        end else begin
            result = sum;
        end
    end

    assign alu_ctl = opc;
    assign is_zero = (result == '0);
    assign ovf     = arith_sum_sel & sum_ovf;
endmodule

// File: rtl/opsel_alu_chk.sv
module opsel_alu_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic [1:0]       op_class,
    input logic [5:0]       fn_code,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [3:0]       alu_ctl,
    input logic [WIDTH-1:0] result,
    input logic             is_zero,
    input logic             ovf
);
    logic unused_fn;
    assign unused_fn = ^fn_code;

    always_comb begin
        a_r1_add_class: assert (op_class != 2'b00 || alu_ctl == 4'b0110)
            else $error("R1 class 00 did not select add");
        a_r2_sub_class: assert (op_class != 2'b01 || alu_ctl == 4'b1110)
            else $error("R2 class 01 did not select subtract");
        a_r4_and_result: assert (alu_ctl != 4'b0000 || result == (opnd_a & opnd_b))
            else $error("R4 and result wrong");
        a_r5_add_result: assert (alu_ctl != 4'b0110 || result == opnd_a + opnd_b)
            else $error("R5 add result wrong");
        a_r6_slt_upper: assert (alu_ctl != 4'b1111 || result[WIDTH-1:1] == '0)
            else $error("R6 slt upper bits set");
        a_r7_no_overflow: assert (!ovf || alu_ctl == 4'b0110 || alu_ctl == 4'b1110)
            else $error("R7 overflow outside add/subtract");
        a_r8_sub_equal_zero: assert (!(alu_ctl == 4'b1110 && opnd_a == opnd_b) || is_zero)
            else $error("R8 equal operands did not give zero");
    end
endmodule

bind opsel_alu opsel_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .op_class (op_class),
    .fn_code  (fn_code),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .alu_ctl  (alu_ctl),
    .result   (result),
    .is_zero  (is_zero),
    .ovf      (ovf)
);

// File: tb/opsel_alu_tb_top.sv
module opsel_alu_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   op_class;
    logic [5:0]   fn_code;
    logic [W-1:0] opnd_a;
    logic [W-1:0] opnd_b;
    logic [3:0]   alu_ctl;
    logic [W-1:0] result;
    logic         is_zero;
    logic         ovf;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    opsel_alu #(.WIDTH(W)) dut_i (
        .op_class (op_class),
        .fn_code  (fn_code),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .alu_ctl  (alu_ctl),
        .result   (result),
        .is_zero  (is_zero),
        .ovf      (ovf)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [W-1:0] pick(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;
            5: return 32'h8000_0001;
            6: return 32'h5555_5555;
            default: return 32'h1234_5678;
        endcase
    endfunction

    function automatic logic [3:0] exp_ctl(input logic [1:0] cls, input logic [5:0] fn);
        if (cls == 2'b00) return 4'b0110;
        if (cls == 2'b01) return 4'b1110;
        case (fn[3:0])
            4'd0:    return 4'b0110;
            4'd2:    return 4'b1110;
            4'd4:    return 4'b0000;
            4'd5:    return 4'b0001;
            4'd6:    return 4'b0010;
            4'd7:    return 4'b0011;
            4'd10:   return 4'b1111;
            default: return 4'b0110;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s cls=%b fn=%b a=%h b=%h act=%h exp=%h",
                     tag, op_class, fn_code, opnd_a, opnd_b, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] cls, input logic [5:0] fn,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        logic [3:0]   ec;
        logic [W-1:0] er;
        bit           eo;
        longint       sa, sb, s;
        string        ctag;
        string        rtag;
        @(posedge clk);
        op_class = cls; fn_code = fn; opnd_a = a; opnd_b = b;
        @(negedge clk);
        ec = exp_ctl(cls, fn);
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        eo = 1'b0;
        case (ec)
            4'b0000: begin er = a & b;    rtag = "R4"; end
            4'b0001: begin er = a | b;    rtag = "R4"; end
            4'b0010: begin er = a ^ b;    rtag = "R4"; end
            4'b0011: begin er = ~(a | b); rtag = "R4"; end
            4'b0110: begin
                er = a + b; rtag = "R5"; s = sa + sb;
                eo = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            4'b1110: begin
                er = a - b; rtag = "R5"; s = sa - sb;
                eo = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            default: begin er = (sa < sb) ? 32'd1 : 32'd0; rtag = "R6"; end
        endcase
        ctag = (cls == 2'b00) ? "R1" : (cls == 2'b01) ? "R2" : "R3";
        chk(alu_ctl == ec, ctag, {28'd0, alu_ctl}, {28'd0, ec});
        chk(result == er, rtag, result, er);
        chk(ovf == eo, "R7", {31'd0, ovf}, {31'd0, eo});
        chk(is_zero == (er == '0), "R8", {31'd0, is_zero}, {31'd0, (er == '0)});
    endtask

    initial begin
        op_class = 2'b00; fn_code = 6'd0; opnd_a = '0; opnd_b = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Idle state after reset: add of zeros
        chk(result == '0, "R5", result, '0);
        chk(is_zero == 1'b1, "R8", {31'd0, is_zero}, 32'd1);
        chk(ovf == 1'b0, "R7", {31'd0, ovf}, 32'd0);
        // Sweep: every class, every function code, every operand pair
        for (int c = 0; c < 4; c++) begin
            for (int f = 0; f < 64; f++) begin
                for (int i = 0; i < 8; i++) begin
                    for (int j = 0; j < 8; j++) begin
                        apply(2'(c), 6'(f), pick(i), pick(j));
                    end
                end
            end
        end
        // R6 overflow-corrected compare corners
        apply(2'b10, 6'b101010, 32'h8000_0000, 32'h0000_0001);
        apply(2'b10, 6'b101010, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule